// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a parallel flash device. Once a program or erase command has been sent to the flash, the block is started with three inputs: the target address, the operation kind, and, for a program, the byte that was meant to be written. It then reads the target location again and again through a simple synchronous read port. Each returned status byte is judged on two bits: bit 7 is the completion flag and bit 5 is the device error flag.

When the device reports that the operation is finished, the block makes one more read to check the stored byte. It then raises a one-cycle done pulse together with a result code. The result stays valid until the next start.

A host-side watchdog limits the number of polling reads, so a device that never finishes still produces an answer. Only one read is in flight at any time: a new request is issued only after the previous data has returned.

Top module: `flash_poll_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `rd_req` are low.
- R2: A `start` seen while `busy` is low begins a new check. Every read request of that check carries the `addr` captured at that start. A new `rd_req` is never raised before the previous read has returned `rd_valid`. A `start` seen while `busy` is high is ignored.
- R3: For a program (`erase`=0), a polling read whose bit 7 equals bit 7 of `wdata` and whose bit 5 is 0 ends polling and starts the verify read. A read where bit 7 differs and bit 5 is 0 triggers another polling read.
- R4: For an erase (`erase`=1), the expected value of bit 7 is 1, and the verify step compares against FFh.
- R5: A polling read with bit 5 = 1 triggers exactly one extra status read. If bit 7 of that extra read matches the expected value, the block goes on to the verify read. If it does not match, the check ends with result 01 (device error).
- R6: The verify read compares all 8 bits with the expected byte (`wdata` for a program, FFh for an erase). A match gives result 00 (pass) and a mismatch gives result 10 (verify mismatch).
- R7: After MAX_POLLS polling reads that each showed bit 7 not matching and bit 5 = 0, the check ends with result 11 (time-out). No verify read is made in that case.
- R8: `done` is high for exactly one cycle when a check ends, and `busy` falls in that same cycle. `result` then holds its value until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a check (accepted only while not busy) |
| erase | input | 1 | 1 = erase check, 0 = program check |
| addr | input | ADDR_W | Location to poll and verify |
| wdata | input | 8 | Intended byte for a program |
| rd_req | output | 1 | Read request, one cycle per read |
| rd_addr | output | ADDR_W | Read address |
| rd_valid | input | 1 | Read data valid, at least one cycle after the request |
| rd_data | input | 8 | Read data |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle end-of-check pulse |
| result | output | 2 | 00 pass, 01 device error, 10 verify mismatch, 11 time-out |

## Verification
A wrong internal state shows up at the ports as a wrong number of read requests for a check, or as a wrong result code. Both can be seen no later than the done pulse of that same check.

A lost captured address, or an accepted second start, shows up at the next read request as a changed `rd_addr`. A broken one-outstanding rule shows up as a request raised while the bench memory still has data pending.

A wrong watchdog bound changes the read count of a time-out check by at least one.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL_READ,
        ST_EVAL,
        ST_RECHECK,
        ST_VERIFY,
        ST_DONE
    } fpc_state_e;

    typedef enum logic [1:0] {
        RES_PASS     = 2'b00,
        RES_DEV_ERR  = 2'b01,
        RES_MISMATCH = 2'b10,
        RES_TIMEOUT  = 2'b11
    } fpc_result_e;

    localparam int FLAG_BIT = 7;
    localparam int ERR_BIT  = 5;

endpackage

// File: rtl/fpc_status_decode.sv
module fpc_status_decode
    import flash_poll_pkg::*;
(
    input  logic [7:0] status,
    input  logic [7:0] expect_byte,
    output logic       flag_ok,
    output logic       err_flag,
    output logic       byte_ok
);
    always_comb begin
        flag_ok  = (status[FLAG_BIT] == expect_byte[FLAG_BIT]);
        err_flag = status[ERR_BIT];
        byte_ok  = (status == expect_byte);
    end
endmodule

// File: rtl/fpc_watchdog.sv
module fpc_watchdog #(
    parameter int MAX_POLLS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(MAX_POLLS + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = cnt_q + 1'b1;
        end
        last = (cnt_q == CW'(MAX_POLLS - 1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> (cnt_q < CW'(MAX_POLLS))); // R7
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MAX_POLLS = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [7:0]        rd_data,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result
);
    typedef struct packed {
        fpc_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        target;
        logic              issued;
        logic              done;
        fpc_result_e       result;
    } regs_t;

    regs_t r_d, r_q;

    logic flag_ok, err_flag, byte_ok;
    logic accept, wd_inc, wd_last;

    fpc_status_decode u_decode (
        .status      (rd_data),
        .expect_byte (r_q.target),
        .flag_ok     (flag_ok),
        .err_flag    (err_flag),
        .byte_ok     (byte_ok)
    );

    fpc_watchdog #(.MAX_POLLS(MAX_POLLS)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (wd_inc),
        .last  (wd_last)
    );

    always_comb begin
        busy   = (r_q.state != ST_IDLE) && (r_q.state != ST_DONE);
        accept = start && !busy;
        wd_inc = (r_q.state == ST_EVAL) && rd_valid && !flag_ok && !err_flag;
        rd_req = (r_q.state == ST_POLL_READ) ||
                 (((r_q.state == ST_RECHECK) || (r_q.state == ST_VERIFY)) && !r_q.issued);
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE, ST_DONE: begin
                if (accept) begin
                    r_d.state  = ST_POLL_READ;
                    r_d.addr   = addr;
                    r_d.target = erase ? 8'hFF : wdata;
                end
            end
            ST_POLL_READ: begin
                r_d.state = ST_EVAL;
            end
            ST_EVAL: begin
                if (rd_valid) begin
                    r_d.issued = 1'b0;
                    if (flag_ok && !err_flag) begin
                        r_d.state = ST_VERIFY;
                    end else if (err_flag) begin
                        r_d.state = ST_RECHECK;
                    end else if (wd_last) begin
                        r_d.state  = ST_DONE;
                        r_d.done   = 1'b1;
                        r_d.result = RES_TIMEOUT;
                    end else begin
                        r_d.state = ST_POLL_READ;
                    end
                end
            end
            ST_RECHECK: begin
                if (!r_q.issued) begin
                    r_d.issued = 1'b1;
                end else if (rd_valid) begin
                    r_d.issued = 1'b0;
                    if (flag_ok) begin
                        r_d.state = ST_VERIFY;
                    end else begin
                        r_d.state  = ST_DONE;
                        r_d.done   = 1'b1;
                        r_d.result = RES_DEV_ERR;
                    end
                end
            end
            ST_VERIFY: begin
                if (!r_q.issued) begin
                    r_d.issued = 1'b1;
                end else if (rd_valid) begin
                    r_d.issued = 1'b0;
                    r_d.state  = ST_DONE;
                    r_d.done   = 1'b1;
                    r_d.result = byte_ok ? RES_PASS : RES_MISMATCH;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state  <= ST_IDLE;
            r_q.addr   <= '0;
            r_q.target <= '0;
            r_q.issued <= 1'b0;
            r_q.done   <= 1'b0;
            r_q.result <= RES_PASS;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_addr = r_q.addr;
    assign done    = r_q.done;
    assign result  = r_q.result;

    AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R2
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(rd_addr)); // R2
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_req); // R1
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(result)); // R8
endmodule

// File: tb/tb_flash_poll_ctrl.sv
module tb_flash_poll_ctrl;
    localparam int AW  = 16;
    localparam int MAX = 10;
    localparam int SC_OK = 0, SC_MISM = 1, SC_ERR_OK = 2, SC_ERR_FAIL = 3, SC_TMO = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic rd_req, rd_valid = 1'b0;
    logic [AW-1:0] rd_addr;
    logic [7:0] rd_data = '0;
    logic busy, done;
    logic [1:0] result;

    int errors = 0, checks = 0, cycles = 0;

    // job description shared with the memory model
    int j_scen = 0, j_n = 0;
    logic [7:0] j_target = '0;
    logic [AW-1:0] j_addr = '0;
    logic mem_clr = 1'b0;

    // memory model state
    int idx = 0, addr_err = 0, overlap = 0, wait_c = 0;
    logic pending = 1'b0;

    flash_poll_ctrl #(.ADDR_W(AW), .MAX_POLLS(MAX)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .erase(erase), .addr(addr),
        .wdata(wdata), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_data(rd_data), .busy(busy), .done(done), .result(result)
    );

    always #4 clk = ~clk; // 125 MHz

    function automatic logic [7:0] resp(int i, logic [7:0] t, int sc, int n, logic [7:0] r);
        logic [7:0] busyb, errb;
        busyb = {~t[7], r[6], 1'b0, r[4:0]};
        errb  = {~t[7], r[6], 1'b1, r[4:0]};
        case (sc)
            SC_OK:       return (i < n) ? busyb : t;
            SC_MISM:     return (i < n) ? busyb : (t ^ 8'h01);
            SC_ERR_OK:   return (i < n) ? busyb : ((i == n) ? errb : t);
            SC_ERR_FAIL: return (i < n) ? busyb : errb;
            default:     return busyb;
        endcase
    endfunction

    function automatic int exp_result(int sc);
        case (sc)
            SC_OK, SC_ERR_OK: return 0;
            SC_ERR_FAIL:      return 1;
            SC_MISM:          return 2;
            default:          return 3;
        endcase
    endfunction

    function automatic int exp_reads(int sc, int n, logic [7:0] t);
        case (sc)
            SC_OK, SC_MISM: return n + 1 + (t[5] ? 1 : 0) + 1;
            SC_ERR_OK:      return n + 3;
            SC_ERR_FAIL:    return n + 2;
            default:        return MAX;
        endcase
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        rd_valid <= 1'b0;
        if (mem_clr) begin
            idx <= 0; addr_err <= 0; overlap <= 0; pending <= 1'b0;
        end else begin
            if (rd_req) begin
                if (pending) overlap <= overlap + 1;
                if (rd_addr != j_addr) addr_err <= addr_err + 1;
                pending <= 1'b1;
                wait_c <= $urandom_range(0, 2);
            end else if (pending) begin
                if (wait_c == 0) begin
                    rd_valid <= 1'b1;
                    rd_data  <= resp(idx, j_target, j_scen, j_n, 8'($urandom));
                    idx      <= idx + 1;
                    pending  <= 1'b0;
                end else begin
                    wait_c <= wait_c - 1;
                end
            end
        end
    end

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic run_job(int sc, int n, bit er, logic [7:0] wd, logic [AW-1:0] ad, bit poke);
        int waited;
        string rq;
        rq = (sc == SC_TMO) ? "R7" : (sc == SC_MISM) ? "R6" :
             (sc == SC_OK) ? (er ? "R4" : "R3") : "R5";
        @(negedge clk);
        j_scen = sc; j_n = n; j_addr = ad;
        j_target = er ? 8'hFF : wd;
        mem_clr = 1'b1;
        @(negedge clk);
        mem_clr = 1'b0;
        start = 1'b1; erase = er; wdata = wd; addr = ad;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; addr = ad ^ 16'h0001; erase = ~er; wdata = ~wd;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R8", "done seen", int'(done), 1);
        check(int'(result) == exp_result(sc), rq, "result", int'(result), exp_result(sc));
        check(idx == exp_reads(sc, n, j_target), rq, "read count", idx, exp_reads(sc, n, j_target));
        check(addr_err == 0 && overlap == 0, "R2", "addr/overlap faults", addr_err + overlap, 0);
        check(busy == 1'b0, "R8", "busy at done", int'(busy), 0);
        @(negedge clk);
        check(done == 1'b0, "R8", "done width", int'(done), 0);
        repeat (3) @(negedge clk);
        check(int'(result) == exp_result(sc) && !busy && !rd_req, "R8", "result held",
              int'(result), exp_result(sc));
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        check(!busy && !done && !rd_req, "R1", "reset outputs",
              int'({busy, done, rd_req}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !rd_req, "R1", "idle after reset",
              int'({busy, done, rd_req}), 0);

        run_job(SC_OK,       3, 1'b0, 8'h5A, 16'h1234, 1'b0); // R3 bit5 clear
        run_job(SC_OK,       2, 1'b0, 8'hA5, 16'h0042, 1'b0); // R3 bit5 set -> recheck
        run_job(SC_OK,       0, 1'b1, 8'h00, 16'h8000, 1'b0); // R4 erase immediate
        run_job(SC_OK,       4, 1'b1, 8'h13, 16'h8001, 1'b0); // R4 erase after busy
        run_job(SC_ERR_OK,   2, 1'b0, 8'h81, 16'h0100, 1'b0); // R5 recovered
        run_job(SC_ERR_FAIL, 1, 1'b0, 8'h01, 16'h0200, 1'b0); // R5 device error
        run_job(SC_ERR_FAIL, 0, 1'b1, 8'h00, 16'h0300, 1'b0); // R5 erase error
        run_job(SC_MISM,     2, 1'b0, 8'hC3, 16'h0400, 1'b0); // R6 program mismatch
        run_job(SC_MISM,     1, 1'b1, 8'h00, 16'h0500, 1'b0); // R6 erase mismatch
        run_job(SC_TMO,      0, 1'b0, 8'h7E, 16'h0600, 1'b0); // R7 time-out
        run_job(SC_OK, MAX - 1, 1'b0, 8'h42, 16'h0700, 1'b0); // R7 last poll completes
        run_job(SC_OK,       5, 1'b0, 8'h11, 16'h0900, 1'b1); // R2 start while busy ignored

        for (int k = 0; k < 40; k++) begin
            int sc;
            sc = $urandom_range(0, 4);
            run_job(sc, $urandom_range(0, MAX - 1), 1'($urandom), 8'($urandom),
                    AW'($urandom), 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d cycles", cycles, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule